// File: doc/BRIEF.md
# I/O Page Register File

This block is the byte-wide register file behind a small handheld console's I/O page. It holds the interrupt flag and enable bytes, the timer control byte, a divider byte, the display status byte, a bank of sound channel registers, the two sound mixer registers (master volume and panning) and the sound status register. A processor reaches it over a plain synchronous bus. It has an address, a read strobe, a write strobe and write data. Read data comes back in the same cycle as the read strobe.

On a read, each register has a fixed mask of unused bits, and the block ORs that mask into the data, so those bits read as one. An address that decodes to no register reads as all ones. Sound register writes are gated by the master power bit in the sound status register. While that bit is clear, a write stores zero. Turning the bit off wipes the channel and mixer registers. The four channel-active bits of the status register come from input ports and cannot be written.

Address map (8-bit): 0x00 interrupt flag, 0x01 interrupt enable, 0x04 divider, 0x05 timer control, 0x08 display status. The channel registers occupy 0x10 to 0x1B. Master volume is at 0x1C, panning at 0x1D and sound status at 0x1E. In the sound status register, bit 7 is the master power bit and bits 3:0 are the channel-active bits.

Top module: `io_page_regs`

## Requirements
- R1: After reset, reads return the following values. Interrupt flag 0xE1, interrupt enable 0xE0, timer control 0xF8, divider 0x00 and display status 0x80. Master volume reads 0x77, panning 0xF3 and every channel register 0x00. Sound status reads 0xF0 ORed with the registered channel-active bits, which gives 0xF1 when channel 0 is active.
- R2: A write to the interrupt flag register stores the written byte ORed with 0xE0, so bits 7:5 always read as one.
- R3: Reads OR in fixed masks on four registers: 0xF8 on timer control, 0xE0 on interrupt enable, 0x80 on display status and 0x70 on sound status.
- R4: A read from an address with no register returns 0xFF. A write to such an address changes no register.
- R5: Read data depends only on the address and the register state in the same cycle as `bus_rd`. While `bus_rd` is low, `bus_rdata` is 0xFF.
- R6: The divider increments by one, wrapping modulo 256, on each clock with `div_step` high. Any write to it clears it to 0x00 whatever the data, and the clear wins over a simultaneous step.
- R7: While the master power bit (sound status bit 7) is clear, a write to a channel, volume or panning register stores 0x00.
- R8: A write to sound status takes only bit 7 from the data. Bits 3:0 follow `chan_active` one clock later and ignore written data.
- R9: A status write that changes the master power bit from one to zero clears all channel, volume and panning registers on the same edge. Setting the bit again restores nothing.
- R10: While the master power bit is set, channel, volume and panning registers store all eight written bits and read them back unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per clock |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| div_step | input | 1 | Divider increment request |
| chan_active | input | 4 | Live channel-active flags |

## Verification
The hardest situation to reach is the power-off transition. The channel and mixer registers must be loaded with non-zero data first, then the master power bit is dropped through a status write, and only then can the wipe and the zero-on-write gating be seen. The stimulus therefore runs the table walk first, which leaves a channel register and the volume register holding known non-zero values. The directed sequence then powers down, reads every affected register, writes while powered down, and powers up again to show that nothing comes back. The divider case where a clear and a step land on the same clock is also driven on purpose.

// File: rtl/iorf_pkg.sv
// Shared constants for the I/O page register file: bus widths,
// fixed register addresses, read masks and reset values.
// Assumes a byte-wide bus with an 8-bit address.
package iorf_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_IRQ_FLAG = 8'h00;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 8'h01;
    localparam logic [ADDR_W-1:0] A_DIVIDER  = 8'h04;
    localparam logic [ADDR_W-1:0] A_TIM_CTL  = 8'h05;
    localparam logic [ADDR_W-1:0] A_DSP_STAT = 8'h08;

    localparam logic [DATA_W-1:0] M_IRQ_FLAG = 8'hE0;
    localparam logic [DATA_W-1:0] M_IRQ_EN   = 8'hE0;
    localparam logic [DATA_W-1:0] M_TIM_CTL  = 8'hF8;
    localparam logic [DATA_W-1:0] M_DSP_STAT = 8'h80;
    localparam logic [DATA_W-1:0] M_SND_STAT = 8'h70;

    localparam logic [DATA_W-1:0] RST_IRQ_FLAG = 8'hE1;
    localparam logic [DATA_W-1:0] RST_VOLUME   = 8'h77;
    localparam logic [DATA_W-1:0] RST_PANNING  = 8'hF3;

    localparam logic [DATA_W-1:0] OPEN_BUS = 8'hFF;
    localparam int NUM_CHAN = 4;
endpackage

// File: rtl/iorf_core_regs.sv
// Core control registers: interrupt flag/enable, timer control,
// display status and divider. Stores raw bytes; read masking is done
// by the read mux. Assumes at most one write per clock.
module iorf_core_regs
    import iorf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              div_step,
    output logic [DATA_W-1:0] irq_flag_q,
    output logic [DATA_W-1:0] irq_en_q,
    output logic [DATA_W-1:0] tim_ctl_q,
    output logic [DATA_W-1:0] dsp_stat_q,
    output logic [DATA_W-1:0] div_q
);
    logic div_clr;
    assign div_clr = wr_en && (addr == A_DIVIDER);

    // Register writes for the plain control bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag_q <= RST_IRQ_FLAG;
            irq_en_q   <= '0;
            tim_ctl_q  <= '0;
            dsp_stat_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_IRQ_FLAG: irq_flag_q <= wdata | M_IRQ_FLAG;
                A_IRQ_EN:   irq_en_q   <= wdata;
                A_TIM_CTL:  tim_ctl_q  <= wdata;
                A_DSP_STAT: dsp_stat_q <= wdata;
                default: ;
            endcase
        end
    end

    // Divider: cleared by any write, otherwise steps on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_clr) begin
            div_q <= '0;
        end else if (div_step) begin
            div_q <= div_q + 1'b1;
        end
    end

    // R6
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIVIDER) |=> (div_q == '0));

    // R2
    irq_top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IRQ_FLAG) |=> (irq_flag_q[7:5] == 3'b111));
endmodule

// File: rtl/iorf_sound_regs.sv
// Sound register bank: CH_REGS channel bytes followed by master volume
// and panning, then the status byte holding the master power bit.
// Writes store zero while power is off; a power-off write wipes the
// bank. Channel-active flags are sampled every clock without reset.
module iorf_sound_regs
    import iorf_pkg::*;
#(
    parameter int CH_REGS = 12,
    parameter int BASE    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_CHAN-1:0]           chan_in,
    output logic [CH_REGS+1:0][DATA_W-1:0] bank_q,
    output logic                          pwr_q,
    output logic [NUM_CHAN-1:0]           chan_q
);
    localparam int NREG = CH_REGS + 2;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(BASE + NREG);

    logic stat_wr;
    logic pwr_off;
    assign stat_wr = wr_en && (addr == A_STATUS);
    assign pwr_off = stat_wr && pwr_q && !wdata[DATA_W-1];

    // Master power bit: only bit 7 of a status write is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= 1'b1;
        else if (stat_wr) pwr_q <= wdata[DATA_W-1];
    end

    // Channel-active flags follow the inputs every clock.
    always_ff @(posedge clk) begin
        chan_q <= chan_in;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_REG = ADDR_W'(BASE + i);
        localparam logic [DATA_W-1:0] RST_V =
            (i == CH_REGS)     ? RST_VOLUME  :
            (i == CH_REGS + 1) ? RST_PANNING : '0;
        logic hit;
        assign hit = wr_en && (addr == A_REG);

        // One bank byte: wipe on power-off, gated store otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) bank_q[i] <= RST_V;
            else if (pwr_off) bank_q[i] <= '0;
            else if (hit) bank_q[i] <= pwr_q ? wdata : '0;
        end
    end

    // R7
    snd_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_q |-> (bank_q == '0));

    // R9
    pwr_off_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_q) && !pwr_q) |-> (bank_q == '0));
endmodule

// File: rtl/iorf_read_mux.sv
// Combinational read path: selects the addressed byte, ORs in its
// unused-bit mask, returns all ones for unmapped addresses and while
// the read strobe is low.
module iorf_read_mux
    import iorf_pkg::*;
#(
    parameter int CH_REGS = 12,
    parameter int BASE    = 16
) (
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              irq_flag_q,
    input  logic [DATA_W-1:0]              irq_en_q,
    input  logic [DATA_W-1:0]              tim_ctl_q,
    input  logic [DATA_W-1:0]              dsp_stat_q,
    input  logic [DATA_W-1:0]              div_q,
    input  logic [CH_REGS+1:0][DATA_W-1:0] bank_q,
    input  logic                           pwr_q,
    input  logic [NUM_CHAN-1:0]            chan_q,
    output logic [DATA_W-1:0]              rdata
);
    localparam int NREG = CH_REGS + 2;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(BASE + NREG);
    localparam int PAD = DATA_W - 1 - NUM_CHAN;

    logic [DATA_W-1:0] sel;

    // Address decode with per-register masks.
    always_comb begin
        sel = OPEN_BUS;
        case (addr)
            A_IRQ_FLAG: sel = irq_flag_q | M_IRQ_FLAG;
            A_IRQ_EN:   sel = irq_en_q   | M_IRQ_EN;
            A_TIM_CTL:  sel = tim_ctl_q  | M_TIM_CTL;
            A_DSP_STAT: sel = dsp_stat_q | M_DSP_STAT;
            A_DIVIDER:  sel = div_q;
            A_STATUS:   sel = {pwr_q, {PAD{1'b0}}, chan_q} | M_SND_STAT;
            default: begin
                for (int i = 0; i < NREG; i++) begin
                    if (addr == ADDR_W'(BASE + i)) sel = bank_q[i];
                end
            end
        endcase
        rdata = rd_en ? sel : OPEN_BUS;
    end
endmodule

// File: rtl/io_page_regs.sv
// Top of the I/O page register file. Ties the core control bytes,
// the sound bank and the read mux to one synchronous byte bus.
// Assumes the sound bank does not overlap the core addresses.
module io_page_regs
    import iorf_pkg::*;
#(
    parameter int SND_CH_REGS = 12,
    parameter int SND_BASE    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              div_step,
    input  logic [3:0]        chan_active
);
    localparam int NREG = SND_CH_REGS + 2;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SND_BASE + NREG);

    logic [DATA_W-1:0] irq_flag_q, irq_en_q, tim_ctl_q, dsp_stat_q, div_q;
    logic [NREG-1:0][DATA_W-1:0] bank_q;
    logic pwr_q;
    logic [NUM_CHAN-1:0] chan_q;

    iorf_core_regs u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .div_step(div_step),
        .irq_flag_q(irq_flag_q), .irq_en_q(irq_en_q), .tim_ctl_q(tim_ctl_q),
        .dsp_stat_q(dsp_stat_q), .div_q(div_q)
    );

    iorf_sound_regs #(.CH_REGS(SND_CH_REGS), .BASE(SND_BASE)) u_snd (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .chan_in(chan_active),
        .bank_q(bank_q), .pwr_q(pwr_q), .chan_q(chan_q)
    );

    iorf_read_mux #(.CH_REGS(SND_CH_REGS), .BASE(SND_BASE)) u_rmux (
        .rd_en(bus_rd), .addr(bus_addr),
        .irq_flag_q(irq_flag_q), .irq_en_q(irq_en_q), .tim_ctl_q(tim_ctl_q),
        .dsp_stat_q(dsp_stat_q), .div_q(div_q),
        .bank_q(bank_q), .pwr_q(pwr_q), .chan_q(chan_q),
        .rdata(bus_rdata)
    );

    // R5
    idle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'hFF));

    // R2
    irq_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_IRQ_FLAG) |-> (bus_rdata[7:5] == 3'b111));

    // R3
    tctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_TIM_CTL) |-> (bus_rdata[7:3] == 5'b11111));

    // R8
    status_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STATUS)
            |-> (bus_rdata[3:0] == $past(chan_active) && bus_rdata[6:4] == 3'b111));
endmodule

// File: tb/io_page_regs_bench.sv
`timescale 1ns/1ps
module io_page_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       div_step = 1'b0;
    logic [3:0] chan_active = 4'b0001;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_page_regs u_io_page_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .div_step(div_step), .chan_active(chan_active)
    );

    typedef struct packed {
        logic       is_wr;
        logic [7:0] a;
        logic [7:0] d;     // write data or expected read
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 8'h05, 8'd2}, '{1'b0, 8'h00, 8'hE5, 8'd2},   // R2
        '{1'b1, 8'h01, 8'h0A, 8'd3}, '{1'b0, 8'h01, 8'hEA, 8'd3},   // R3
        '{1'b1, 8'h05, 8'h05, 8'd3}, '{1'b0, 8'h05, 8'hFD, 8'd3},   // R3
        '{1'b1, 8'h08, 8'h44, 8'd3}, '{1'b0, 8'h08, 8'hC4, 8'd3},   // R3
        '{1'b1, 8'h1A, 8'h5A, 8'd10}, '{1'b0, 8'h1A, 8'h5A, 8'd10}, // R10
        '{1'b1, 8'h1C, 8'h31, 8'd10}, '{1'b0, 8'h1C, 8'h31, 8'd10}, // R10
        '{1'b1, 8'h02, 8'h00, 8'd4}, '{1'b0, 8'h02, 8'hFF, 8'd4},   // R4
        '{1'b0, 8'h00, 8'hE5, 8'd4},
        '{1'b1, 8'h1F, 8'h12, 8'd4}, '{1'b0, 8'h1F, 8'hFF, 8'd4},   // R4
        '{1'b0, 8'h80, 8'hFF, 8'd4},
        '{1'b1, 8'h00, 8'hFF, 8'd2}, '{1'b0, 8'h00, 8'hFF, 8'd2},   // R2
        '{1'b1, 8'h00, 8'h00, 8'd2}, '{1'b0, 8'h00, 8'hE0, 8'd2}    // R2
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdc(input logic [7:0] a, input logic [7:0] e, input int req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, e);
        bus_rd = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); div_step = 1'b1;
        end
        @(negedge clk); div_step = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rdc(8'h00, 8'hE1, 1); rdc(8'h01, 8'hE0, 1); rdc(8'h05, 8'hF8, 1);
        rdc(8'h04, 8'h00, 1); rdc(8'h08, 8'h80, 1); rdc(8'h1C, 8'h77, 1);
        rdc(8'h1D, 8'hF3, 1); rdc(8'h10, 8'h00, 1); rdc(8'h1B, 8'h00, 1);
        rdc(8'h1E, 8'hF1, 1);

        // R5 idle read returns all ones
        @(negedge clk); bus_addr = 8'h01; bus_rd = 1'b0; #1;
        check(5, bus_rdata, 8'hFF);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) wr(VECS[i].a, VECS[i].d);
            else rdc(VECS[i].a, VECS[i].d, int'(VECS[i].req));
        end

        // R6 divider stepping, clearing, clear-over-step, wrap
        steps(3);               rdc(8'h04, 8'h03, 6);
        wr(8'h04, 8'hAB);       rdc(8'h04, 8'h00, 6);
        steps(2);
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 8'h55; bus_wr = 1'b1; div_step = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; div_step = 1'b0;
        rdc(8'h04, 8'h00, 6);
        steps(258);             rdc(8'h04, 8'h02, 6);

        // R8 status: live channel bits, only bit 7 writable
        @(negedge clk); chan_active = 4'b1010;
        @(negedge clk);
        rdc(8'h1E, 8'hFA, 8);
        wr(8'h1E, 8'h8F);       rdc(8'h1E, 8'hFA, 8);
        @(negedge clk); chan_active = 4'b0110;
        @(negedge clk);
        rdc(8'h1E, 8'hF6, 8);

        // R9 power-off wipe
        wr(8'h11, 8'h77);       rdc(8'h11, 8'h77, 10);
        wr(8'h1E, 8'h0F);
        rdc(8'h1E, 8'h76, 9);   rdc(8'h11, 8'h00, 9);
        rdc(8'h1A, 8'h00, 9);   rdc(8'h1C, 8'h00, 9);
        rdc(8'h1D, 8'h00, 9);

        // R7 writes while powered down store zero
        wr(8'h12, 8'h33);       rdc(8'h12, 8'h00, 7);
        wr(8'h1C, 8'h55);       rdc(8'h1C, 8'h00, 7);
        wr(8'h01, 8'h1F);       rdc(8'h01, 8'hFF, 3);

        // R9 power back on restores nothing; R10 writes land again
        wr(8'h1E, 8'h80);
        rdc(8'h1E, 8'hF6, 9);   rdc(8'h11, 8'h00, 9);
        rdc(8'h1C, 8'h00, 9);
        wr(8'h12, 8'h33);       rdc(8'h12, 8'h33, 10);
        wr(8'h1D, 8'hC5);       rdc(8'h1D, 8'hC5, 10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule